// File: doc/BRIEF.md
# Sample-Paced Boost Switch Controller

This block decides, one ADC conversion at a time, whether the switch transistor of a discontinuous-mode boost converter conducts. It has no timer of its own. Each time a conversion result arrives, the controller either ends a switch pulse that is in progress or decides whether to start one. It then asks for the next conversion, so the ADC's conversion time sets the loop's pace and also the width of every on-pulse.

Each decision depends on three programmable thresholds and on the previous sample:

- A floor threshold: below it, the switch stays off.
- A trend threshold: between the floor and this threshold, the switch may fire only when the output is not rising.
- A ceiling threshold: at or above it, the switch never fires.

Each time enable rises, the controller runs a short start-up sequence before regulation begins:

- It clears its previous-sample memory.
- It holds the switch low.
- It emits a one-cycle ADC setup strobe.

Top module: `boost_pulse_ctrl`

## Requirements
- R1: In regulation, every accepted sample (sample valid high while enabled) produces a conversion request that is high for exactly the next clock cycle. A request is also issued in the cycle after start-up ends.
- R2: If the switch output is high when a sample is accepted, the switch goes low in the next cycle whatever the sample value. An on-pulse therefore never spans two samples.
- R3: With the switch low, a sample below the floor threshold leaves the switch low.
- R4: With the switch low, a sample at or above the floor threshold but below the trend threshold turns the switch on only if the sample is not greater than the previous sample and is below the ceiling.
- R5: With the switch low, a sample at or above the trend threshold turns the switch on exactly when it is below the ceiling threshold.
- R6: On each rising of enable, the ADC setup strobe is high for one cycle (the cycle after the edge) and the previous sample is cleared to zero. The switch is low during start-up, and the first conversion request follows in the next cycle.
- R7: Every accepted sample becomes the previous sample, on every decision path, including the path that ends a pulse.
- R8: While enable is low, the switch and the conversion request are low from the next cycle on, and samples are ignored.
- R9: Samples and thresholds are DATA_W-bit (default 10) unsigned values, and all comparisons are unsigned, including at 0 and at the full-scale code 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulation enable; a rising edge starts the start-up sequence |
| smp_valid | input | 1 | Conversion-complete strobe |
| smp_data | input | DATA_W | Conversion result, unsigned |
| thr_floor | input | DATA_W | Lowest threshold |
| thr_trend | input | DATA_W | Threshold below which the trend test applies |
| thr_ceiling | input | DATA_W | Threshold at or above which the switch never fires |
| sw_drive | output | 1 | Switch transistor drive |
| conv_req | output | 1 | Start-conversion request, one cycle |
| adc_setup | output | 1 | One-cycle ADC setup strobe at activation |

## Verification
The assertions check on every cycle the rules that hold for any stimulus:

- a pulse ends on the next sample;
- a conversion request follows each accepted sample;
- disable forces the switch and the request low;
- the history register clears at activation and loads each accepted sample;
- floor and trend vetoes keep the switch low.

The full decision table needs the bench's sweeps. These drive long sample streams around the thresholds and at full scale and compare against an arithmetic model. They also cover cases no single-cycle property can show: a stored pulse-ending sample governing the next trend test, and a cleared history changing the decision after re-activation.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   sw;
        logic   conv;
        logic   cfg;
    } seq_state_t;

endpackage

// File: rtl/bpc_decide.sv
module bpc_decide #(
    parameter int DATA_W = 10
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] prev,
    input  logic              sw_now,
    input  logic [DATA_W-1:0] thr_floor,
    input  logic [DATA_W-1:0] thr_trend,
    input  logic [DATA_W-1:0] thr_ceiling,
    output logic              sw_next
);
    logic below_floor;
    logic below_trend;
    logic below_ceil;
    logic rising;
    logic permit;

    always_comb begin
        below_floor = sample < thr_floor;
        below_trend = sample < thr_trend;
        below_ceil  = sample < thr_ceiling;
        rising      = sample > prev;
        permit      = 1'b0;
        if (!below_floor) begin
            permit = below_trend ? !rising : 1'b1;
        end
        sw_next = !sw_now && permit && below_ceil;
    end

    always_comb begin
        // R2
        end_pulse_chk: assert (!(sw_now && sw_next));
    end
endmodule

// File: rtl/bpc_hist.sv
module bpc_hist #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] sample,
    output logic [DATA_W-1:0] prev
);
    logic [DATA_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (clear)     prev_d = '0;
        else if (load) prev_d = sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign prev = prev_q;

    // R6
    hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> prev_q == '0);
    // R7
    hist_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> prev_q == $past(sample));
endmodule

// File: rtl/bpc_seq.sv
module bpc_seq
    import bpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic smp_valid,
    input  logic sw_next,
    output logic sw_now,
    output logic conv_req,
    output logic adc_setup,
    output logic hist_clear,
    output logic hist_load
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.conv = 1'b0;
        st_d.cfg  = 1'b0;
        if (!enable) begin
            st_d.phase = PH_IDLE;
            st_d.sw    = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase = PH_SETUP;
                    st_d.cfg   = 1'b1;
                    st_d.sw    = 1'b0;
                end
                PH_SETUP: begin
                    st_d.phase = PH_RUN;
                    st_d.conv  = 1'b1;
                end
                PH_RUN: begin
                    if (smp_valid) begin
                        st_d.sw   = sw_next;
                        st_d.conv = 1'b1;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, sw: 1'b0, conv: 1'b0, cfg: 1'b0};
        else        st_q <= st_d;
    end

    assign sw_now     = st_q.sw;
    assign conv_req   = st_q.conv;
    assign adc_setup  = st_q.cfg;
    assign hist_clear = enable && (st_q.phase == PH_IDLE);
    assign hist_load  = enable && smp_valid && (st_q.phase == PH_RUN);

    // R1
    conv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hist_load |=> conv_req);
    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_load && sw_now) |=> !sw_now);
    // R8
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sw_now && !conv_req && !adc_setup));
    // R6
    setup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_setup |=> (!adc_setup && !sw_now));
endmodule

// File: rtl/boost_pulse_ctrl.sv
module boost_pulse_ctrl #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] thr_floor,
    input  logic [DATA_W-1:0] thr_trend,
    input  logic [DATA_W-1:0] thr_ceiling,
    output logic              sw_drive,
    output logic              conv_req,
    output logic              adc_setup
);
    logic [DATA_W-1:0] prev;
    logic sw_now, sw_next, hist_clear, hist_load;

    bpc_decide #(.DATA_W(DATA_W)) u_decide (
        .sample(smp_data), .prev(prev), .sw_now(sw_now),
        .thr_floor(thr_floor), .thr_trend(thr_trend), .thr_ceiling(thr_ceiling),
        .sw_next(sw_next)
    );

    bpc_hist #(.DATA_W(DATA_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .clear(hist_clear), .load(hist_load),
        .sample(smp_data), .prev(prev)
    );

    bpc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
        .sw_next(sw_next), .sw_now(sw_now), .conv_req(conv_req),
        .adc_setup(adc_setup), .hist_clear(hist_clear), .hist_load(hist_load)
    );

    assign sw_drive = sw_now;

    // R3
    floor_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_load && smp_data < thr_floor) |=> !sw_drive);
    // R4
    trend_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_load && smp_data < thr_trend && smp_data > prev) |=> !sw_drive);
    // R5
    ceiling_veto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_load && smp_data >= thr_ceiling) |=> !sw_drive);
endmodule

// File: tb/boost_pulse_ctrl_bench.sv
`timescale 1ns/1ps
module boost_pulse_ctrl_bench;
    localparam int DW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [DW-1:0] t_lo = 10'd100, t_mid = 10'd200, t_hi = 10'd300;
    logic sw_drive, conv_req, adc_setup;

    int n_cmp = 0;
    int n_bad = 0;
    int m_prev = 0;
    bit m_sw = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    boost_pulse_ctrl #(.DATA_W(DW)) u_boost_pulse_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
        .smp_data(smp_data), .thr_floor(t_lo), .thr_trend(t_mid),
        .thr_ceiling(t_hi), .sw_drive(sw_drive), .conv_req(conv_req),
        .adc_setup(adc_setup)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic activate();
        enable = 1'b1;
        tick();
        chk(adc_setup == 1'b1, "R6 setup strobe", adc_setup, 1);
        chk(sw_drive == 1'b0, "R6 switch low in setup", sw_drive, 0);
        tick();
        chk(conv_req == 1'b1, "R1 R6 first request", conv_req, 1);
        chk(adc_setup == 1'b0, "R6 strobe one cycle", adc_setup, 0);
        tick();
        chk(conv_req == 1'b0, "R1 request one cycle", conv_req, 0);
        m_prev = 0;
        m_sw = 1'b0;
    endtask

    task automatic send(input int s, input string pre);
        bit exp;
        string tag;
        if (m_sw) begin
            exp = 1'b0; tag = "R2";
        end else if (s < t_lo) begin
            exp = 1'b0; tag = "R3";
        end else if (s < t_mid) begin
            exp = (s <= m_prev) && (s < t_hi); tag = "R4 R7";
        end else begin
            exp = (s < t_hi); tag = "R5";
        end
        smp_valid = 1'b1;
        smp_data = s[DW-1:0];
        tick();
        smp_valid = 1'b0;
        chk(sw_drive == exp, {pre, " ", tag, " decision"}, sw_drive, exp);
        chk(conv_req == 1'b1, "R1 request after sample", conv_req, 1);
        tick();
        chk(conv_req == 1'b0, "R1 request one cycle", conv_req, 0);
        chk(sw_drive == exp, "R2 switch held between samples", sw_drive, exp);
        m_prev = s;
        m_sw = exp;
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick();
        chk(sw_drive == 1'b0, "R8 reset switch", sw_drive, 0);
        chk(conv_req == 1'b0, "R8 reset request", conv_req, 0);
        chk(adc_setup == 1'b0, "R6 reset strobe", adc_setup, 0);
        tick();
        rst_n = 1'b1;
        tick();
        activate();

        // directed path tests, floor 100 trend 200 ceiling 300
        send(250, "dir");
        send(180, "dir R7");
        send(170, "dir R7");
        send(190, "dir");
        send(195, "dir R4");
        send(50, "dir R3");
        send(300, "dir R5");
        send(299, "dir R5");

        // disable while switch high, sample ignored
        send(150, "dir");
        send(250, "dir");
        chk(sw_drive == 1'b1, "R8 precondition switch high", sw_drive, 1);
        enable = 1'b0;
        tick();
        chk(sw_drive == 1'b0, "R8 disable drops switch", sw_drive, 0);
        chk(conv_req == 1'b0, "R8 disable no request", conv_req, 0);
        smp_valid = 1'b1;
        smp_data = 10'd250;
        tick();
        smp_valid = 1'b0;
        chk(conv_req == 1'b0, "R8 sample ignored request", conv_req, 0);
        chk(sw_drive == 1'b0, "R8 sample ignored switch", sw_drive, 0);
        tick();
        activate();
        send(150, "R6 cleared history");

        // randomized sweep around thresholds
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(int'(lfsr) % 400, "sweep");
        end

        // full-scale sweep with high thresholds
        t_lo = 10'd900; t_mid = 10'd1000; t_hi = 10'd1023;
        tick();
        for (int s = 0; s < 1024; s++) send(s, "R9 up");
        for (int s = 1023; s >= 0; s--) send(s, "R9 down");
        t_lo = 10'd0; t_mid = 10'd0; t_hi = 10'd1023;
        tick();
        send(0, "R9 zero");
        send(1023, "R9 full");
        send(1023, "R9 full");
        send(1022, "R9 near full");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule